// File: doc/BRIEF.md
# Coexistence Receive Status Message Generator

This block follows the receive path through each PPDU and reports it to a coexistence arbiter as short 64-bit status messages. It latches the PHY-side description of the PPDU when reception begins: rate, bandwidth, stream count and RSSI. It then watches per-MPDU header results, FCS results and the end or abort of the PPDU. It emits up to three messages per PPDU, each tagged with the event that caused it: reception start, first good FCS of an aggregate, and end, with the end tagged either as normal or as a PHY nap abort. Each message carries the current remaining packet time. It also carries a remaining exchange time that grows by the frame's duration field once a frame with a good FCS has been seen.

The fields that belong to one user are taken from the first header that triggered reporting and are frozen for the rest of the PPDU. The response-expected flag collects requests from every reporting header. One configuration input chooses what gets reported. When it is clear, only frames that pass the address filter and are addressed to this station are reported, and the three filter-related bits read zero. When it is set, every header reports, and those bits carry their real values. Messages leave through a valid/ready port and wait in a small queue when the arbiter stalls.

Top module: `coex_rx_status_gen`

## Requirements
- R1: After reset, `msg_valid_o` is 0 until an event produces a message.
- R2: The first reporting header of a PPDU emits a message with status code 0 (start). Later headers in the same PPDU emit no further start message. Rate, bandwidth, stream count and RSSI come from the values latched at `phy_start_i`.
- R3: A message with status code 1 is emitted on the first good FCS of a PPDU, only when the first reporting header flagged an aggregate. At most one such message is emitted per PPDU.
- R4: PPDU end emits status code 2 and a nap abort emits status code 3, with nap taking precedence when both are asserted together. A PPDU that produced no start message produces no end message.
- R5: The response-expected bit (word 0 bit 2) is 0 in start messages. In code 1, 2 and 3 messages it is the OR of `hdr_resp_i` over all reporting headers of the PPDU.
- R6: Word 1 bits [31:16] equal word 1 bits [15:0], the remaining packet time, until a good FCS is seen. From that FCS on, they equal the remaining packet time plus the duration of the last reporting header before that FCS, saturating at 0xFFFF.
- R7: With `cfg_report_all` = 0, only headers with both filter pass and directed set report, and word 0 bits 12 (filter), 13 (aggregate) and 14 (directed) are 0. With `cfg_report_all` = 1, every header reports, and these bits carry the first user's values.
- R8: Frame type [29:27], retry [31 is more data, 30 is retry], single MPDU [11] and aggregate come from the first reporting header and are not changed by later headers in the same PPDU.
- R9: Word 0 layout: [1:0] code, [2] response, [7:3] rate, [10:8] bandwidth (0=20, 1=40, 2=80, 3=160, 4=320, 5=240 MHz), [11] single, [12] filter, [13] aggregate, [14] directed, [15] always 0, [18:16] streams minus one, [26:19] RSSI, [29:27] type (0 data, 1 management, 2 beacon, 3 control request, 4 control response, 5 other), [30] retry, [31] more data.
- R10: A message is held stable while `msg_valid_o` = 1 and `msg_ready_i` = 0. Up to QDEPTH pending messages are queued and delivered in order without loss.
- R11: At most one event is taken per cycle, in the priority `phy_start_i` > end/nap > FCS > header. A lower-priority event in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_report_all | input | 1 | 1 = also report filtered-out frames |
| phy_start_i | input | 1 | PPDU reception begins (pulse) |
| phy_rate_i | input | 5 | Receive rate, latched at start |
| phy_bw_i | input | 3 | Bandwidth code, latched at start |
| phy_nss_i | input | 3 | Stream count minus one, latched at start |
| phy_rssi_i | input | 8 | RSSI, latched at start |
| phy_rem_time_i | input | 16 | Current remaining packet time |
| hdr_valid_i | input | 1 | MPDU header result valid (pulse) |
| hdr_pass_i | input | 1 | Header passed the address filter |
| hdr_directed_i | input | 1 | Receiver address matches this station |
| hdr_type_i | input | 3 | Frame type code |
| hdr_retry_i | input | 1 | Retry bit of frame control |
| hdr_more_i | input | 1 | More-data bit of frame control |
| hdr_ampdu_i | input | 1 | Reception is an aggregate |
| hdr_single_i | input | 1 | Reception is a single MPDU |
| hdr_resp_i | input | 1 | A response transmission must follow |
| hdr_dur_i | input | 16 | Duration field of the header |
| fcs_valid_i | input | 1 | FCS result valid (pulse) |
| fcs_ok_i | input | 1 | FCS passed |
| phy_end_i | input | 1 | PPDU reception ended (pulse) |
| phy_nap_i | input | 1 | Reception aborted by PHY nap (pulse) |
| msg_valid_o | output | 1 | Message available |
| msg_ready_i | input | 1 | Arbiter accepts the message |
| msg_word0_o | output | 32 | Message word 0 |
| msg_word1_o | output | 32 | Message word 1: exchange time [31:16], packet time [15:0] |

## Verification
The assertions check the following on every cycle: the reserved bit is zero, the filter bits are masked when filtered-out reporting is off, start messages never carry the response bit, and the exchange time never drops below the packet time. They also check that a stalled message stays stable, that a second start message is never emitted within one PPDU, and that the queue is never pushed while full. Only the bench's scenarios can show which events produce a message at all and the first-user freezing of per-user fields. The same holds for the switch of the exchange time on the first good FCS, its saturation, nap precedence, the absence of messages for unreported PPDUs, and in-order delivery after a long stall.

// File: rtl/coex_rx_pkg.sv
package coex_rx_pkg;

    localparam int TIME_W = 16;

    typedef enum logic [1:0] {
        EV_START     = 2'd0,
        EV_FIRST_FCS = 2'd1,
        EV_END       = 2'd2,
        EV_NAP_END   = 2'd3
    } ev_code_e;

    // Field order is the wire layout of word 0, MSB first
    typedef struct packed {
        logic       more;
        logic       retry;
        logic [2:0] ftype;
        logic [7:0] rssi;
        logic [2:0] nss;
        logic       rsvd;
        logic       directed;
        logic       aggr;
        logic       filt;
        logic       single;
        logic [2:0] bw;
        logic [4:0] rate;
        logic       resp;
        ev_code_e   code;
    } word0_t;

    typedef struct packed {
        logic [TIME_W-1:0] xchg_time;
        logic [TIME_W-1:0] pkt_time;
    } word1_t;

    typedef struct packed {
        word1_t w1;
        word0_t w0;
    } msg_t;

endpackage

// File: rtl/coex_rx_sat_add.sv
module coex_rx_sat_add #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o
);
    logic [W:0] wide;

    always_comb begin
        wide  = {1'b0, a_i} + {1'b0, b_i};
        sum_o = wide[W] ? {W{1'b1}} : wide[W-1:0];
    end
endmodule

// File: rtl/coex_rx_msg_fifo.sv
module coex_rx_msg_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    output logic [W-1:0] dout_o,
    output logic         valid_o,
    output logic         full_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        ptr_d   = ptr_q;
        valid_o = (ptr_q.cnt != '0);
        full_o  = (ptr_q.cnt == CW'(DEPTH));
        do_pop  = pop_i && valid_o;
        do_push = push_i && !full_o;
        if (do_push) ptr_d.wr = (ptr_q.wr == LAST) ? '0 : ptr_q.wr + 1'b1;
        if (do_pop)  ptr_d.rd = (ptr_q.rd == LAST) ? '0 : ptr_q.rd + 1'b1;
        case ({do_push, do_pop})
            2'b10:   ptr_d.cnt = ptr_q.cnt + 1'b1;
            2'b01:   ptr_d.cnt = ptr_q.cnt - 1'b1;
            default: ptr_d.cnt = ptr_q.cnt;
        endcase
        dout_o = mem_q[ptr_q.rd];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[ptr_q.wr] <= din_i;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o); // R10
endmodule

// File: rtl/coex_rx_status_gen.sv
module coex_rx_status_gen
    import coex_rx_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_report_all,
    input  logic              phy_start_i,
    input  logic [4:0]        phy_rate_i,
    input  logic [2:0]        phy_bw_i,
    input  logic [2:0]        phy_nss_i,
    input  logic [7:0]        phy_rssi_i,
    input  logic [TIME_W-1:0] phy_rem_time_i,
    input  logic              hdr_valid_i,
    input  logic              hdr_pass_i,
    input  logic              hdr_directed_i,
    input  logic [2:0]        hdr_type_i,
    input  logic              hdr_retry_i,
    input  logic              hdr_more_i,
    input  logic              hdr_ampdu_i,
    input  logic              hdr_single_i,
    input  logic              hdr_resp_i,
    input  logic [TIME_W-1:0] hdr_dur_i,
    input  logic              fcs_valid_i,
    input  logic              fcs_ok_i,
    input  logic              phy_end_i,
    input  logic              phy_nap_i,
    output logic              msg_valid_o,
    input  logic              msg_ready_i,
    output logic [31:0]       msg_word0_o,
    output logic [31:0]       msg_word1_o
);
    localparam int MSG_W = $bits(msg_t);

    typedef struct packed {
        logic              active;
        logic              started;
        logic              fcs_sent;
        logic              xchg_mode;
        logic              resp;
        logic [4:0]        rate;
        logic [2:0]        bw;
        logic [2:0]        nss;
        logic [7:0]        rssi;
        logic [2:0]        utype;
        logic              uretry;
        logic              umore;
        logic              usingle;
        logic              uaggr;
        logic              upass;
        logic              udir;
        logic [TIME_W-1:0] dur_last;
        logic [TIME_W-1:0] xchg_dur;
    } trk_t;

    trk_t trk_d, trk_q;

    logic              qualify, ev_end, ev_fcs, ev_hdr;
    logic              push;
    logic              use_xchg;
    logic [TIME_W-1:0] add_b, add_sum;
    msg_t              msg;
    logic [MSG_W-1:0]  q_dout;
    logic              q_full;
    msg_t              head;

    coex_rx_sat_add #(.W(TIME_W)) u_add (
        .a_i   (phy_rem_time_i),
        .b_i   (add_b),
        .sum_o (add_sum)
    );

    always_comb begin
        trk_d   = trk_q;
        push    = 1'b0;
        msg     = '0;

        qualify = cfg_report_all || (hdr_pass_i && hdr_directed_i);
        ev_end  = !phy_start_i && trk_q.active && (phy_end_i || phy_nap_i);
        ev_fcs  = !phy_start_i && !ev_end && trk_q.active && trk_q.started
                  && fcs_valid_i && fcs_ok_i;
        ev_hdr  = !phy_start_i && !ev_end && !(trk_q.active && fcs_valid_i)
                  && trk_q.active && hdr_valid_i && qualify;

        add_b    = trk_q.xchg_mode ? trk_q.xchg_dur : trk_q.dur_last;
        use_xchg = trk_q.xchg_mode || ev_fcs;

        // message fields: frozen first-user values, or the header now arriving
        msg.w0.rate  = trk_q.rate;
        msg.w0.bw    = trk_q.bw;
        msg.w0.nss   = trk_q.nss;
        msg.w0.rssi  = trk_q.rssi;
        msg.w0.rsvd  = 1'b0;
        msg.w0.resp  = trk_q.resp;
        if (trk_q.started) begin
            msg.w0.ftype    = trk_q.utype;
            msg.w0.retry    = trk_q.uretry;
            msg.w0.more     = trk_q.umore;
            msg.w0.single   = trk_q.usingle;
            msg.w0.filt     = cfg_report_all && trk_q.upass;
            msg.w0.aggr     = cfg_report_all && trk_q.uaggr;
            msg.w0.directed = cfg_report_all && trk_q.udir;
        end else begin
            msg.w0.ftype    = hdr_type_i;
            msg.w0.retry    = hdr_retry_i;
            msg.w0.more     = hdr_more_i;
            msg.w0.single   = hdr_single_i;
            msg.w0.filt     = cfg_report_all && hdr_pass_i;
            msg.w0.aggr     = cfg_report_all && hdr_ampdu_i;
            msg.w0.directed = cfg_report_all && hdr_directed_i;
        end
        msg.w1.pkt_time  = phy_rem_time_i;
        msg.w1.xchg_time = use_xchg ? add_sum : phy_rem_time_i;

        if (phy_start_i) begin
            trk_d         = '0;
            trk_d.active  = 1'b1;
            trk_d.rate    = phy_rate_i;
            trk_d.bw      = phy_bw_i;
            trk_d.nss     = phy_nss_i;
            trk_d.rssi    = phy_rssi_i;
        end else if (ev_end) begin
            push         = trk_q.started;
            msg.w0.code  = phy_nap_i ? EV_NAP_END : EV_END;
            trk_d.active = 1'b0;
            trk_d.started = 1'b0;
        end else if (ev_fcs) begin
            if (!trk_q.xchg_mode) begin
                trk_d.xchg_mode = 1'b1;
                trk_d.xchg_dur  = trk_q.dur_last;
            end
            if (trk_q.uaggr && !trk_q.fcs_sent) begin
                push           = 1'b1;
                msg.w0.code    = EV_FIRST_FCS;
                trk_d.fcs_sent = 1'b1;
            end
        end else if (ev_hdr) begin
            trk_d.dur_last = hdr_dur_i;
            trk_d.resp     = trk_q.resp || hdr_resp_i;
            if (!trk_q.started) begin
                push          = 1'b1;
                msg.w0.code   = EV_START;
                msg.w0.resp   = 1'b0;
                trk_d.started = 1'b1;
                trk_d.utype   = hdr_type_i;
                trk_d.uretry  = hdr_retry_i;
                trk_d.umore   = hdr_more_i;
                trk_d.usingle = hdr_single_i;
                trk_d.uaggr   = hdr_ampdu_i;
                trk_d.upass   = hdr_pass_i;
                trk_d.udir    = hdr_directed_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    coex_rx_msg_fifo #(.W(MSG_W), .DEPTH(QDEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .din_i   (msg),
        .pop_i   (msg_ready_i),
        .dout_o  (q_dout),
        .valid_o (msg_valid_o),
        .full_o  (q_full)
    );

    always_comb begin
        head        = msg_t'(q_dout);
        msg_word0_o = head.w0;
        msg_word1_o = head.w1;
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid_o |-> (msg_word0_o[15] == 1'b0)); // R9
    AST_FILTER_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid_o && !cfg_report_all) |-> (msg_word0_o[14:12] == 3'b000)); // R7
    AST_START_NO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid_o && msg_word0_o[1:0] == 2'd0) |-> !msg_word0_o[2]); // R5
    AST_XCHG_NOT_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid_o |-> (msg_word1_o[31:16] >= msg_word1_o[15:0])); // R6
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(msg_word0_o)
                                           && $stable(msg_word1_o))); // R10
    AST_START_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (push && msg.w0.code == EV_START) |-> !trk_q.started); // R2
    AST_QUEUE_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !q_full); // R10
endmodule

// File: tb/tb_coex_rx_status_gen.sv
`timescale 1ns/100ps
module tb_coex_rx_status_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg = 1'b0;
    logic        p_start = 0, h_valid = 0, h_pass = 0, h_dir = 0, h_retry = 0, h_more = 0;
    logic        h_ampdu = 0, h_single = 0, h_resp = 0, f_valid = 0, f_ok = 0, p_end = 0, p_nap = 0;
    logic [4:0]  p_rate = 0;
    logic [2:0]  p_bw = 0, p_nss = 0, h_type = 0;
    logic [7:0]  p_rssi = 0;
    logic [15:0] rem = 0, h_dur = 0;
    logic        ready = 1'b1;
    logic        valid;
    logic [31:0] w0, w1;

    int tests = 0;
    int fails = 0;

    typedef struct { logic [63:0] word; string tag; } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    coex_rx_status_gen dut (
        .clk(clk), .rst_n(rst_n), .cfg_report_all(cfg),
        .phy_start_i(p_start), .phy_rate_i(p_rate), .phy_bw_i(p_bw), .phy_nss_i(p_nss),
        .phy_rssi_i(p_rssi), .phy_rem_time_i(rem),
        .hdr_valid_i(h_valid), .hdr_pass_i(h_pass), .hdr_directed_i(h_dir), .hdr_type_i(h_type),
        .hdr_retry_i(h_retry), .hdr_more_i(h_more), .hdr_ampdu_i(h_ampdu), .hdr_single_i(h_single),
        .hdr_resp_i(h_resp), .hdr_dur_i(h_dur),
        .fcs_valid_i(f_valid), .fcs_ok_i(f_ok), .phy_end_i(p_end), .phy_nap_i(p_nap),
        .msg_valid_o(valid), .msg_ready_i(ready), .msg_word0_o(w0), .msg_word1_o(w1)
    );

    function automatic logic [31:0] mk0(input int code, resp, rate, bw, single, filt, aggr,
                                         dir, nss, rssi, typ, retry, more);
        logic [31:0] r;
        r = 32'(code) | (32'(resp) << 2) | (32'(rate) << 3) | (32'(bw) << 8)
          | (32'(single) << 11) | (32'(filt) << 12) | (32'(aggr) << 13) | (32'(dir) << 14)
          | (32'(nss) << 16) | (32'(rssi) << 19) | (32'(typ) << 27) | (32'(retry) << 30)
          | (32'(more) << 31);
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic expect_msg(input string tag, input logic [31:0] e0, input int xchg, input int pkt);
        exp_t e;
        e.word = {16'(xchg), 16'(pkt), e0};
        e.tag  = tag;
        sb.push_back(e);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_start(input int rate, bw, nss, rssi);
        p_start = 1; p_rate = 5'(rate); p_bw = 3'(bw); p_nss = 3'(nss); p_rssi = 8'(rssi);
        tick();
        p_start = 0;
    endtask

    task automatic set_hdr(input int pass, dir, typ, retry, more, aggr, single, resp, dur);
        h_valid = 1; h_pass = 1'(pass); h_dir = 1'(dir); h_type = 3'(typ); h_retry = 1'(retry);
        h_more = 1'(more); h_ampdu = 1'(aggr); h_single = 1'(single); h_resp = 1'(resp);
        h_dur = 16'(dur);
    endtask

    task automatic do_hdr(input int pass, dir, typ, retry, more, aggr, single, resp, dur);
        set_hdr(pass, dir, typ, retry, more, aggr, single, resp, dur);
        tick();
        h_valid = 0;
    endtask

    task automatic do_fcs(input int ok);
        f_valid = 1; f_ok = 1'(ok);
        tick();
        f_valid = 0;
    endtask

    task automatic do_end(input int endp, nap);
        p_end = 1'(endp); p_nap = 1'(nap);
        tick();
        p_end = 0; p_nap = 0; h_valid = 0;
    endtask

    task automatic drain();
        while (sb.size() != 0) tick();
        tick();
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && valid && ready) begin
            if (sb.size() == 0) begin
                tests++;
                fails++;
                $display("FAIL R4 unexpected message got %h expected none", {w1, w0});
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, {w1, w0}, e.word);
            end
        end
    end

    task automatic finish_run();
        if (sb.size() != 0) begin
            tests++;
            fails++;
            $display("FAIL R10 missing %0d messages got 0 expected %0d", sb.size(), sb.size());
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [63:0] held;
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1: idle after reset
        tests++;
        if (valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 got valid=%b expected 0", valid);
        end

        // Aggregate, single user: start, first-FCS, end (R2 R3 R5 R6 R8 R9)
        rem = 1000;
        do_start(5, 2, 1, 8'hA5);
        expect_msg("R2 start", mk0(0,0,5,2,0,0,0,0,1,8'hA5,0,1,0), 1000, 1000);
        do_hdr(1,1,0,1,0,1,0,1,100);
        rem = 950;
        do_hdr(1,1,1,0,1,1,1,0,50);         // R8 later user must not change fields
        rem = 940;
        do_fcs(0);                          // bad FCS: no message, no switch
        rem = 900;
        expect_msg("R3 first-fcs R5 R6 R8", mk0(1,1,5,2,0,0,0,0,1,8'hA5,0,1,0), 950, 900);
        do_fcs(1);
        rem = 800;
        do_fcs(1);                          // R3 second good FCS: silent
        rem = 10;
        expect_msg("R4 end R6", mk0(2,1,5,2,0,0,0,0,1,8'hA5,0,1,0), 60, 10);
        do_end(1, 0);
        drain();

        // Non-aggregate: no first-FCS message (R3)
        rem = 500;
        do_start(3, 0, 0, 8'h40);
        expect_msg("R2 single start", mk0(0,0,3,0,1,0,0,0,0,8'h40,4,0,0), 500, 500);
        do_hdr(1,1,4,0,0,0,1,0,20);
        rem = 400;
        do_fcs(1);
        rem = 300;
        expect_msg("R3 no-fcs-msg R6 end", mk0(2,0,3,0,1,0,0,0,0,8'h40,4,0,0), 320, 300);
        do_end(1, 0);
        drain();

        // Nap abort with end and a header in the same cycle (R4 R11)
        rem = 700;
        do_start(7, 4, 3, 8'h10);
        expect_msg("R2 start nap case", mk0(0,0,7,4,0,0,0,0,3,8'h10,3,0,0), 700, 700);
        do_hdr(1,1,3,0,0,0,0,0,5);
        rem = 600;
        set_hdr(1,1,3,0,0,0,0,1,9);         // R11 header ignored: resp stays 0
        expect_msg("R4 nap R11", mk0(3,0,7,4,0,0,0,0,3,8'h10,3,0,0), 600, 600);
        do_end(1, 1);
        drain();

        // Not directed with filtering on: nothing at all (R4 R7)
        rem = 100;
        do_start(2, 1, 0, 8'h22);
        do_hdr(1,0,0,0,0,1,0,1,7);
        do_hdr(0,1,0,0,0,1,0,1,7);
        do_fcs(1);
        do_end(1, 0);
        repeat (4) tick();
        tests++;
        if (valid !== 1'b0) begin
            fails++;
            $display("FAIL R7 R4 got valid=%b expected 0", valid);
        end

        // Report-all mode: filter bits carry first user values (R7 R8)
        cfg = 1;
        rem = 200;
        do_start(1, 5, 7, 8'hFF);
        expect_msg("R7 start report-all", mk0(0,0,1,5,0,0,1,1,7,8'hFF,2,0,0), 200, 200);
        do_hdr(0,1,2,0,0,1,0,0,48);
        do_hdr(1,1,5,1,1,0,1,0,64);
        rem = 100;
        expect_msg("R7 R8 fcs report-all", mk0(1,0,1,5,0,0,1,1,7,8'hFF,2,0,0), 164, 100);
        do_fcs(1);
        rem = 50;
        expect_msg("R7 end report-all", mk0(2,0,1,5,0,0,1,1,7,8'hFF,2,0,0), 114, 50);
        do_end(1, 0);
        drain();
        cfg = 0;

        // Saturation of the exchange time (R6)
        rem = 16'hFFF0;
        do_start(0, 0, 0, 0);
        expect_msg("R6 start sat", mk0(0,0,0,0,0,0,0,0,0,0,0,0,0), 16'hFFF0, 16'hFFF0);
        do_hdr(1,1,0,0,0,1,0,0,16'h0100);
        expect_msg("R6 saturate", mk0(1,0,0,0,0,0,0,0,0,0,0,0,0), 16'hFFFF, 16'hFFF0);
        do_fcs(1);
        rem = 5;
        expect_msg("R6 after sat", mk0(2,0,0,0,0,0,0,0,0,0,0,0,0), 16'h0105, 5);
        do_end(1, 0);
        drain();

        // Back-pressure: three messages queued, held, then drained in order (R10)
        ready = 0;
        rem = 300;
        do_start(9, 3, 2, 8'h33);
        expect_msg("R10 queued 1", mk0(0,0,9,3,0,0,0,0,2,8'h33,1,0,1), 300, 300);
        do_hdr(1,1,1,0,1,1,0,1,30);
        rem = 250;
        expect_msg("R10 queued 2", mk0(1,1,9,3,0,0,0,0,2,8'h33,1,0,1), 280, 250);
        do_fcs(1);
        rem = 200;
        expect_msg("R10 queued 3", mk0(2,1,9,3,0,0,0,0,2,8'h33,1,0,1), 230, 200);
        do_end(1, 0);
        held = {w1, w0};
        repeat (3) tick();
        check("R10 hold", {valid, w1, w0}, {1'b1, held});
        ready = 1;
        drain();

        finish_run();
    end
endmodule